// File: doc/BRIEF.md
# Opcode-Decoded Bit-Slice ALU

This block is a purely combinational arithmetic and logic unit. It takes two operand words and a 3-bit opcode and returns a result word and a carry-out. A single operation decoder turns the opcode into four control values: a flag that inverts operand A, a flag that inverts operand B, the carry fed into the least significant slice, and a 2-bit selector that chooses the slice output. These control values go to every bit slice.

Each slice may invert its two operand bits. It then forms their AND, OR, XOR and full-adder sum, and a 4-way selector passes one of the four on. The slices are chained so that the carry ripples from bit 0 upward. Subtraction is built from the adder path: B is inverted and the carry into bit 0 is forced to 1. NOR is built from the AND path with both operands inverted, by De Morgan's law. The carry-out is forced to zero whenever the adder path is not selected.

The selector encoding is fixed: 00 picks AND, 01 picks OR, 10 picks the sum and 11 picks XOR. The decoder behaves as a fixed mapping with no state. The modes are AND, OR, XOR, ADD, SUB, NOR and a fallback mode for unused opcodes. No mode depends on the mode before it.

Top module: `alu_inv_core`

## Requirements
- R1: Opcode 3'b000 gives result = A AND B and carry_out = 0.
- R2: Opcode 3'b001 gives result = A OR B and carry_out = 0.
- R3: Opcode 3'b100 gives result = A XOR B and carry_out = 0.
- R4: Opcode 3'b011 gives result = (A + B) mod 2^WIDTH, and carry_out is the carry out of the top bit.
- R5: Opcode 3'b010 gives result = (A - B) mod 2^WIDTH, and carry_out = 1 exactly when A >= B as unsigned values (no borrow).
- R6: Opcode 3'b101 gives result = NOT (A OR B) and carry_out = 0.
- R7: The unused opcodes 3'b110 and 3'b111 behave like opcode 3'b000: result = A AND B and carry_out = 0.
- R8: carry_out is 0 for every opcode other than 3'b010 and 3'b011, even when the operands would make the adder carry.
- R9: The block has no clock. result and carry_out follow a change of the inputs within the same time step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH (16) | First operand |
| opnd_b | input | WIDTH (16) | Second operand |
| opcode | input | 3 | Operation code |
| result | output | WIDTH (16) | Selected slice outputs |
| carry_out | output | 1 | Top-bit carry, gated by the sum path |

## Verification
A table of hand-computed vectors covers each opcode on operands chosen to separate similar paths:
- Disjoint and overlapping bit masks tell AND, OR and XOR apart.
- An all-ones plus one addition shows the carry rippling through every slice.
- Subtractions with A above, below and equal to B separate the borrow cases.
- All-ones operands under AND and the unused opcodes show that carry-out is masked.

Random operands under all eight opcodes are then compared against an arithmetic reference model. A final directed step changes the inputs between clock edges to show that the outputs follow without any clock.

// File: rtl/alu_inv_pkg.sv
`timescale 1ns/1ps
package alu_inv_pkg;

    // Opcode values decoded by the shared decoder
    localparam logic [2:0] OPC_AND = 3'b000;
    localparam logic [2:0] OPC_OR  = 3'b001;
    localparam logic [2:0] OPC_SUB = 3'b010;
    localparam logic [2:0] OPC_ADD = 3'b011;
    localparam logic [2:0] OPC_XOR = 3'b100;
    localparam logic [2:0] OPC_NOR = 3'b101;

    // Slice output selector; the encoding is seen by every slice
    typedef enum logic [1:0] {
        PICK_AND = 2'b00,
        PICK_OR  = 2'b01,
        PICK_SUM = 2'b10,
        PICK_XOR = 2'b11
    } pick_e;

    typedef struct packed {
        logic  flip_a;
        logic  flip_b;
        logic  seed_carry;
        pick_e pick;
    } ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
`timescale 1ns/1ps
module alu_op_decode
    import alu_inv_pkg::*;
(
    input  logic [2:0] opcode,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl.flip_a     = 1'b0;
        ctrl.flip_b     = 1'b0;
        ctrl.seed_carry = 1'b0;
        ctrl.pick       = PICK_AND;
        unique case (opcode)
            OPC_AND: ctrl.pick = PICK_AND;
            OPC_OR:  ctrl.pick = PICK_OR;
            OPC_XOR: ctrl.pick = PICK_XOR;
            OPC_ADD: ctrl.pick = PICK_SUM;
            OPC_SUB: begin
                ctrl.pick       = PICK_SUM;
                ctrl.flip_b     = 1'b1;
                ctrl.seed_carry = 1'b1;
            end
            OPC_NOR: begin
                ctrl.pick   = PICK_AND;
                ctrl.flip_a = 1'b1;
                ctrl.flip_b = 1'b1;
            end
            default: ctrl.pick = PICK_AND;
        endcase
    end

    // R5: an injected carry only ever comes with an inverted B on the sum path
    always_comb begin
        if (ctrl.seed_carry)
            assert_seed_with_sub_R5: assert (ctrl.flip_b && ctrl.pick == PICK_SUM)
                else $error("seed carry without subtract setup");
    end

endmodule

// File: rtl/alu_bit_slice.sv
`timescale 1ns/1ps
module alu_bit_slice
    import alu_inv_pkg::*;
(
    input  logic  a_bit,
    input  logic  b_bit,
    input  logic  c_in,
    input  logic  flip_a,
    input  logic  flip_b,
    input  pick_e pick,
    output logic  res_bit,
    output logic  c_out
);

    logic a_eff;
    logic b_eff;
    logic sum_bit;

    always_comb begin
        a_eff   = a_bit ^ flip_a;
        b_eff   = b_bit ^ flip_b;
        sum_bit = a_eff ^ b_eff ^ c_in;
        c_out   = (a_eff & b_eff) | (a_eff & c_in) | (b_eff & c_in);
        unique case (pick)
            PICK_AND: res_bit = a_eff & b_eff;
            PICK_OR:  res_bit = a_eff | b_eff;
            PICK_SUM: res_bit = sum_bit;
            PICK_XOR: res_bit = a_eff ^ b_eff;
            default:  res_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_inv_core.sv
`timescale 1ns/1ps
module alu_inv_core
    import alu_inv_pkg::*;
#(
    parameter int WIDTH = 16
)(
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       opcode,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    localparam int TOP = WIDTH - 1;

    ctrl_t ctrl;
    logic  top_carry;

    alu_op_decode i_decode (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic c_in_w;
        logic c_out_w;
        if (i == 0) begin : g_seed
            assign c_in_w = ctrl.seed_carry;
        end else begin : g_link
            assign c_in_w = g_bit[i-1].c_out_w;
        end
        alu_bit_slice i_slice (
            .a_bit   (opnd_a[i]),
            .b_bit   (opnd_b[i]),
            .c_in    (c_in_w),
            .flip_a  (ctrl.flip_a),
            .flip_b  (ctrl.flip_b),
            .pick    (ctrl.pick),
            .res_bit (result[i]),
            .c_out   (c_out_w)
        );
    end

    assign top_carry = g_bit[TOP].c_out_w;
    assign carry_out = (ctrl.pick == PICK_SUM) ? top_carry : 1'b0;

    // Port-level checks of the rippled slices against word arithmetic
    always_comb begin
        if (opcode == OPC_ADD)
            assert_add_word_R4: assert ({carry_out, result} ==
                ({1'b0, opnd_a} + {1'b0, opnd_b}))
                else $error("add mismatch");
        if (opcode == OPC_SUB)
            assert_sub_word_R5: assert ({carry_out, result} ==
                ({1'b0, opnd_a} + {1'b0, ~opnd_b} + (WIDTH+1)'(1)))
                else $error("subtract mismatch");
        if (opcode == OPC_NOR)
            assert_nor_word_R6: assert (result == ~(opnd_a | opnd_b))
                else $error("nor mismatch");
        if (opcode[2:1] == 2'b11)
            assert_spare_as_and_R7: assert (result == (opnd_a & opnd_b))
                else $error("unused opcode not AND");
        if (opcode != OPC_ADD && opcode != OPC_SUB)
            assert_carry_masked_R8: assert (carry_out == 1'b0)
                else $error("carry leaked");
    end

endmodule

// File: tb/test_alu_inv_core.sv
`timescale 1ns/1ps
module test_alu_inv_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [2:0]  opcode = '0;
    logic [15:0] result;
    logic        carry_out;
    int          n_run = 0;
    int          n_fail = 0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    alu_inv_core #(.WIDTH(16)) i_alu_inv_core (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .opcode    (opcode),
        .result    (result),
        .carry_out (carry_out)
    );

    // {opcode, a, b, expected result, expected carry}
    localparam int NV = 14;
    localparam logic [51:0] VEC [NV] = '{
        {3'b000, 16'hFF0F, 16'h0FF0, 16'h0F00, 1'b0},
        {3'b001, 16'hF000, 16'h000F, 16'hF00F, 1'b0},
        {3'b100, 16'hAAAA, 16'hFFFF, 16'h5555, 1'b0},
        {3'b011, 16'h1234, 16'h4321, 16'h5555, 1'b0},
        {3'b011, 16'hFFFF, 16'h0001, 16'h0000, 1'b1},
        {3'b010, 16'h0005, 16'h0003, 16'h0002, 1'b1},
        {3'b010, 16'h0003, 16'h0005, 16'hFFFE, 1'b0},
        {3'b010, 16'h1234, 16'h1234, 16'h0000, 1'b1},
        {3'b101, 16'h0F0F, 16'h00FF, 16'hF000, 1'b0},
        {3'b110, 16'hFF0F, 16'h0FF0, 16'h0F00, 1'b0},
        {3'b111, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0},
        {3'b101, 16'h0000, 16'h0000, 16'hFFFF, 1'b0},
        {3'b000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0},
        {3'b010, 16'h0000, 16'h0000, 16'h0000, 1'b1}
    };

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b100:  return "R3";
            3'b011:  return "R4";
            3'b010:  return "R5";
            3'b101:  return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [16:0] model(input logic [2:0] op,
                                          input logic [15:0] a,
                                          input logic [15:0] b);
        case (op)
            3'b001:  return {1'b0, a | b};
            3'b100:  return {1'b0, a ^ b};
            3'b011:  return {1'b0, a} + {1'b0, b};
            3'b010:  return {(a >= b), a - b};
            3'b101:  return {1'b0, ~(a | b)};
            default: return {1'b0, a & b};
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] exp_r, input logic exp_c);
        n_run++;
        if (result !== exp_r || carry_out !== exp_c) begin
            n_fail++;
            $display("FAIL %s: op=%b a=%h b=%h actual %h/%b expected %h/%b",
                     tag, opcode, opnd_a, opnd_b, result, carry_out, exp_r, exp_c);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
        @(posedge clk);
        opcode = op;
        opnd_a = a;
        opnd_b = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle inputs: all-zero AND (R1)
        check("R1", 16'h0000, 1'b0);

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][51:49], VEC[k][48:33], VEC[k][32:17]);
            check(req_of(VEC[k][51:49]), VEC[k][16:1], VEC[k][0]);
        end

        // R8: adder-carrying operands under every non-add opcode
        for (int op = 0; op < 8; op++) begin
            if (op != 2 && op != 3) begin
                apply(3'(op), 16'hFFFF, 16'hFFFF);
                check("R8", model(3'(op), 16'hFFFF, 16'hFFFF) & 17'h0FFFF,
                      1'b0);
            end
        end

        // Random operands for every opcode
        for (int n = 0; n < 400; n++) begin
            for (int op = 0; op < 8; op++) begin
                logic [15:0] ra;
                logic [15:0] rb;
                logic [16:0] ex;
                ra = 16'($urandom);
                rb = 16'($urandom);
                ex = model(3'(op), ra, rb);
                apply(3'(op), ra, rb);
                check(req_of(3'(op)), ex[15:0], ex[16]);
            end
        end

        // R9: change inputs between edges, outputs follow without a clock edge
        @(posedge clk);
        #0.5;
        opcode = 3'b011;
        opnd_a = 16'h8000;
        opnd_b = 16'h8000;
        #0.5;
        check("R9", 16'h0000, 1'b1);
        opcode = 3'b010;
        opnd_a = 16'h0001;
        opnd_b = 16'h0002;
        #0.5;
        check("R9", 16'hFFFF, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule